// File: doc/BRIEF.md
# Converter Output Data Formatter

This block sits between the sampling core of a dual-channel converter and its output pins. Each sample period it takes one I sample and one Q sample, each 8 bits wide, together with one out-of-range flag per channel. After a fixed pipeline latency it presents them on a primary output bus and a delayed output bus, along with a registered output data clock. Three output formats are supported. Single data rate uses a selectable launch edge. Double data rate can run without demultiplexing. Double data rate can also run with 1:2 demultiplexing, where pairs of consecutive samples are spread over the primary and delayed buses.

The block is clocked by a tick clock `clk` running at twice the sample rate. One sample period is two ticks, so the output data clock can be built as an ordinary register. Two configuration inputs choose the format. `ddr_mode` selects single or double data rate. `edge_demux` has two meanings. With `ddr_mode` low it picks the launch edge. With `ddr_mode` high it switches demultiplexing on or off. Any change on these two inputs causes a synchronous restart of the output phase. The pipeline then refills from empty, and the outputs stay at zero until it has.

Top module: `ofmt_top`

## Requirements
- R1: In single data rate mode (`ddr_mode`=0), `dclk_o` toggles on every tick, so its period equals one sample period, which is the data rate of each bus.
- R2: In single data rate mode, every change of the primary bus happens on the same tick edge at which `dclk_o` goes to the level of `edge_demux`. A value of 1 gives a rising `dclk_o` edge and a value of 0 gives a falling edge.
- R3: Samples are captured on the first tick edge after reset or restart, and on every second edge after that. In the non-demultiplexed formats (`ddr_mode`=0, or `ddr_mode`=1 with `edge_demux`=0), the primary bus shows sample k right after capture edge k+13, where 13 is the `LATENCY` parameter. The delayed bus stays all-zero in these formats.
- R4: In double data rate modes, `dclk_o` starts low after reset or restart. It changes only on the tick edges where bus data is updated. Without demultiplexing it toggles at every capture edge, which is half the data rate.
- R5: In 1:2 demultiplexed mode (`ddr_mode`=1, `edge_demux`=1), the buses update together on capture edge k+14, for each odd sample index k. The primary bus takes sample k and the delayed bus takes the older sample k-1. This adds one sample period of systematic delay to the primary bus.
- R6: Each out-of-range flag travels with its own sample and leaves on the same bus, in the same cycle, as that sample's data.
- R7: A change of `ddr_mode` or `edge_demux` restarts the block on the next tick edge. Both buses read zero after that edge and stay zero until enough new samples have been captured to refill the pipeline.
- R8: While `rst` is high, both buses are zero. `dclk_o` is high only in the falling-edge single data rate mode, and low in the other modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| in_i | input | 8 | I channel sample |
| in_q | input | 8 | Q channel sample |
| in_i_ovr | input | 1 | I channel out-of-range flag |
| in_q_ovr | input | 1 | Q channel out-of-range flag |
| ddr_mode | input | 1 | 0: single data rate, 1: double data rate |
| edge_demux | input | 1 | Launch edge in single data rate (1 rising), demux enable in double data rate (1 on) |
| pri_i | output | 8 | Primary bus, I data |
| pri_q | output | 8 | Primary bus, Q data |
| pri_i_ovr | output | 1 | Primary bus, I out-of-range |
| pri_q_ovr | output | 1 | Primary bus, Q out-of-range |
| dly_i | output | 8 | Delayed bus, I data |
| dly_q | output | 8 | Delayed bus, Q data |
| dly_i_ovr | output | 1 | Delayed bus, I out-of-range |
| dly_q_ovr | output | 1 | Delayed bus, Q out-of-range |
| dclk_o | output | 1 | Output data clock |

## Verification
The formatter is driven with three kinds of sample streams. A counting ramp gives every sample index a distinct value, so a one-period error in latency or a swapped pair order shows up at once. A stream that alternates between all-zero and all-one samples, with the flags in opposite phase, separates the primary bus from the delayed bus and shows any slip between the flags and their data. Random streams cover the data paths more broadly. These streams are run in all four formats, with restarts triggered both by reset and by mode changes, and with one run too short to refill the pipeline.

// File: rtl/ofmt_pkg.sv
package ofmt_pkg;

    localparam int SMP_W = 8;

    typedef struct packed {
        logic [SMP_W-1:0] i;
        logic [SMP_W-1:0] q;
        logic             i_ovr;
        logic             q_ovr;
    } smp_t;

    // {ddr_mode, edge_demux}
    typedef enum logic [1:0] {
        FMT_SDR_FALL  = 2'b00,
        FMT_SDR_RISE  = 2'b01,
        FMT_DDR_FLAT  = 2'b10,
        FMT_DDR_DEMUX = 2'b11
    } fmt_mode_e;

    function automatic fmt_mode_e decode_mode(input logic ddr, input logic dual);
        return fmt_mode_e'({ddr, dual});
    endfunction

    function automatic logic mode_is_ddr(input fmt_mode_e m);
        return m[1];
    endfunction

    // level of the data clock before the first capture edge
    function automatic logic start_level(input fmt_mode_e m);
        return (m == FMT_SDR_FALL);
    endfunction

endpackage

// File: rtl/ofmt_seq.sv
module ofmt_seq
    import ofmt_pkg::*;
#(
    parameter int LAT = 13
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      ddr_mode,
    input  logic      edge_demux,
    output fmt_mode_e mode_q,
    output logic      restart,
    output logic      strobe,
    output logic      upd_flat,
    output logic      upd_pair,
    output logic      clk_step,
    output logic      load_lvl
);
    localparam int   FILL_MAX = LAT + 2;
    localparam int   FW       = $clog2(FILL_MAX + 1);
    localparam logic SKIP_PAR = logic'((LAT + 1) % 2);

    fmt_mode_e     req;
    logic          ph;
    logic          par;
    logic [FW-1:0] fill;
    logic          pair_slot;

    assign req      = decode_mode(ddr_mode, edge_demux);
    assign restart  = !rst && (req != mode_q);
    assign strobe   = !restart && !ph;
    assign load_lvl = start_level(req);

    // every second capture edge, aligned so the first pair is samples 0 and 1
    assign pair_slot = strobe && (par != SKIP_PAR);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            ph     <= 1'b0;
            par    <= 1'b0;
            fill   <= '0;
            mode_q <= req;
        end else begin
            ph <= ~ph;
            if (strobe) begin
                par <= ~par;
                if (fill != FW'(FILL_MAX))
                    fill <= fill + FW'(1);
            end
        end
    end

    assign upd_flat = strobe && (mode_q != FMT_DDR_DEMUX) && (fill >= FW'(LAT));
    assign upd_pair = pair_slot && (mode_q == FMT_DDR_DEMUX) && (fill >= FW'(LAT + 1));

    always_comb begin
        unique case (mode_q)
            FMT_DDR_FLAT:  clk_step = strobe;
            FMT_DDR_DEMUX: clk_step = pair_slot;
            default:       clk_step = 1'b1;
        endcase
    end

endmodule

// File: rtl/ofmt_pipe.sv
module ofmt_pipe
    import ofmt_pkg::*;
#(
    parameter int DEPTH = 15
) (
    input  logic               clk,
    input  logic               clr,
    input  logic               shift,
    input  smp_t               din,
    output smp_t [DEPTH-1:0]   taps
);
    smp_t [DEPTH-1:0] line;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            smp_t src;
            if (g == 0) begin : g_head
                assign src = din;
            end else begin : g_body
                assign src = line[g-1];
            end
            always_ff @(posedge clk) begin
                if (clr)
                    line[g] <= '0;
                else if (shift)
                    line[g] <= src;
            end
        end
    endgenerate

    assign taps = line;

endmodule

// File: rtl/ofmt_dclk.sv
module ofmt_dclk (
    input  logic clk,
    input  logic load,
    input  logic load_lvl,
    input  logic step,
    output logic dclk
);
    always_ff @(posedge clk) begin
        if (load)
            dclk <= load_lvl;
        else if (step)
            dclk <= ~dclk;
    end
endmodule

// File: rtl/ofmt_out.sv
module ofmt_out
    import ofmt_pkg::*;
#(
    parameter int LAT   = 13,
    parameter int DEPTH = 15
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             upd_flat,
    input  logic             upd_pair,
    input  smp_t [DEPTH-1:0] taps,
    output smp_t             pri,
    output smp_t             dly
);
    always_ff @(posedge clk) begin
        if (clr) begin
            pri <= '0;
            dly <= '0;
        end else if (upd_flat) begin
            pri <= taps[LAT-1];
            dly <= '0;
        end else if (upd_pair) begin
            pri <= taps[LAT];
            dly <= taps[LAT+1];
        end
    end
endmodule

// File: rtl/ofmt_top.sv
module ofmt_top
    import ofmt_pkg::*;
#(
    parameter int LATENCY = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SMP_W-1:0] in_i,
    input  logic [SMP_W-1:0] in_q,
    input  logic             in_i_ovr,
    input  logic             in_q_ovr,
    input  logic             ddr_mode,
    input  logic             edge_demux,
    output logic [SMP_W-1:0] pri_i,
    output logic [SMP_W-1:0] pri_q,
    output logic             pri_i_ovr,
    output logic             pri_q_ovr,
    output logic [SMP_W-1:0] dly_i,
    output logic [SMP_W-1:0] dly_q,
    output logic             dly_i_ovr,
    output logic             dly_q_ovr,
    output logic             dclk_o
);
    localparam int DEPTH = LATENCY + 2;

    fmt_mode_e        mode_q;
    logic             restart, strobe, upd_flat, upd_pair, clk_step, load_lvl;
    logic             clr;
    smp_t             din, pri_s, dly_s;
    smp_t [DEPTH-1:0] taps;

    assign din = '{i: in_i, q: in_q, i_ovr: in_i_ovr, q_ovr: in_q_ovr};
    assign clr = rst || restart;

    ofmt_seq #(.LAT(LATENCY)) u_seq (
        .clk(clk), .rst(rst), .ddr_mode(ddr_mode), .edge_demux(edge_demux),
        .mode_q(mode_q), .restart(restart), .strobe(strobe),
        .upd_flat(upd_flat), .upd_pair(upd_pair),
        .clk_step(clk_step), .load_lvl(load_lvl)
    );

    ofmt_pipe #(.DEPTH(DEPTH)) u_pipe (
        .clk(clk), .clr(clr), .shift(strobe), .din(din), .taps(taps)
    );

    ofmt_out #(.LAT(LATENCY), .DEPTH(DEPTH)) u_out (
        .clk(clk), .clr(clr), .upd_flat(upd_flat), .upd_pair(upd_pair),
        .taps(taps), .pri(pri_s), .dly(dly_s)
    );

    ofmt_dclk u_dclk (
        .clk(clk), .load(clr), .load_lvl(load_lvl), .step(clk_step), .dclk(dclk_o)
    );

    assign pri_i     = pri_s.i;
    assign pri_q     = pri_s.q;
    assign pri_i_ovr = pri_s.i_ovr;
    assign pri_q_ovr = pri_s.q_ovr;
    assign dly_i     = dly_s.i;
    assign dly_q     = dly_s.q;
    assign dly_i_ovr = dly_s.i_ovr;
    assign dly_q_ovr = dly_s.q_ovr;

endmodule

// File: rtl/ofmt_chk.sv
module ofmt_chk
    import ofmt_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      restart,
    input fmt_mode_e mode_q,
    input logic      dclk,
    input smp_t      pri,
    input smp_t      dly
);
    p_sdr_toggle_r1: assert property (@(posedge clk) disable iff (rst)
        (!mode_is_ddr(mode_q) && !$past(restart) && !$past(rst)) |-> (dclk != $past(dclk)));

    p_sdr_edge_r2: assert property (@(posedge clk) disable iff (rst)
        (!mode_is_ddr(mode_q) && !$past(restart) && !$past(rst) && (pri != $past(pri)))
        |-> ((dclk == (mode_q == FMT_SDR_RISE)) && (dclk != $past(dclk))));

    p_dly_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_q != FMT_DDR_DEMUX) |-> (dly == '0));

    p_ddr_phase_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_is_ddr(mode_q) && !$past(restart) && !$past(rst)
         && ((pri != $past(pri)) || (dly != $past(dly)))) |-> (dclk != $past(dclk)));

    p_pair_gap_r5: assert property (@(posedge clk) disable iff (rst)
        ((mode_q == FMT_DDR_DEMUX) && !$past(restart) && !$past(rst) && (dclk != $past(dclk)))
        |=> ($stable(dclk) || $past(restart)));

    p_restart_clear_r7: assert property (@(posedge clk) disable iff (rst)
        restart |=> ((pri == '0) && (dly == '0)));

endmodule

bind ofmt_top ofmt_chk u_chk (
    .clk(clk), .rst(rst), .restart(restart), .mode_q(mode_q),
    .dclk(dclk_o), .pri(pri_s), .dly(dly_s)
);

// File: tb/ofmt_top_test.sv
module ofmt_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 13;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_i = '0, in_q = '0;
    logic       in_i_ovr = 1'b0, in_q_ovr = 1'b0;
    logic       ddr_mode = 1'b0, edge_demux = 1'b1;
    logic [7:0] pri_i, pri_q, dly_i, dly_q;
    logic       pri_i_ovr, pri_q_ovr, dly_i_ovr, dly_q_ovr, dclk_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [17:0] hist [0:255];

    ofmt_top #(.LATENCY(LAT)) uut (
        .clk(clk), .rst(rst), .in_i(in_i), .in_q(in_q),
        .in_i_ovr(in_i_ovr), .in_q_ovr(in_q_ovr),
        .ddr_mode(ddr_mode), .edge_demux(edge_demux),
        .pri_i(pri_i), .pri_q(pri_q), .pri_i_ovr(pri_i_ovr), .pri_q_ovr(pri_q_ovr),
        .dly_i(dly_i), .dly_q(dly_q), .dly_i_ovr(dly_i_ovr), .dly_q_ovr(dly_q_ovr),
        .dclk_o(dclk_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [17:0] make_sample(input int k, input int pat);
        logic [7:0] a;
        case (pat)
            1: begin
                a = k[0] ? 8'hFF : 8'h00;
                return {a, ~a, k[0], ~k[0]};
            end
            2: return {8'(k), 8'(255 - k), (k % 3 == 0), (k % 5 == 0)};
            default: return 18'($urandom);
        endcase
    endfunction

    task automatic drive_sample(input int k, input int pat);
        hist[k] = make_sample(k, pat);
        {in_i, in_q, in_i_ovr, in_q_ovr} = hist[k];
    endtask

    task automatic check_tick(input int t, input logic ddr, input logic ed);
        int m = t / 2;
        logic [17:0] ep = '0;
        logic [17:0] ed_bus = '0;
        logic [17:0] ap, ad;
        logic ec;
        bit filling;
        bit demux = ddr && ed;
        string tg;
        if (!demux) begin
            filling = (m < LAT);
            if (!filling) ep = hist[m - LAT];
        end else begin
            int mu = m - LAT - 1;
            filling = (mu < 1);
            if (!filling) begin
                int k = (mu % 2 == 1) ? mu : mu - 1;
                ep     = hist[k];
                ed_bus = hist[k - 1];
            end
        end
        if (!ddr) ec = (t % 2 == 0) ? ed : ~ed;
        else if (!ed) ec = logic'((m + 1) % 2);
        else begin
            int n = 0;
            for (int j = 0; j <= m; j++) if ((j + LAT + 1) % 2 == 1) n++;
            ec = logic'(n % 2);
        end
        ap = {pri_i, pri_q, pri_i_ovr, pri_q_ovr};
        ad = {dly_i, dly_q, dly_i_ovr, dly_q_ovr};
        tg = filling ? "R7" : (demux ? "R5" : "R3");
        chk(tg, "primary data", 32'(ap[17:2]), 32'(ep[17:2]));
        chk(filling ? "R7" : "R6", "primary flags", 32'(ap[1:0]), 32'(ep[1:0]));
        chk(tg, "delayed bus", 32'(ad), 32'(ed_bus));
        if (!ddr) chk((t % 2 == 0) ? "R2" : "R1", "dclk", 32'(dclk_o), 32'(ec));
        else      chk("R4", "dclk", 32'(dclk_o), 32'(ec));
    endtask

    task automatic run_seg(input logic ddr, input logic ed, input int nsamp,
                           input int pat, input bit use_rst);
        @(negedge clk);
        ddr_mode   = ddr;
        edge_demux = ed;
        if (use_rst) begin
            rst = 1'b1;
            @(posedge clk);
            @(negedge clk);
            chk("R8", "reset primary", 32'({pri_i, pri_q, pri_i_ovr, pri_q_ovr}), 32'h0);
            chk("R8", "reset delayed", 32'({dly_i, dly_q, dly_i_ovr, dly_q_ovr}), 32'h0);
            chk("R8", "reset dclk", 32'(dclk_o), 32'(!ddr && !ed));
            rst = 1'b0;
        end else begin
            @(posedge clk);
            @(negedge clk);
            chk("R7", "restart primary", 32'({pri_i, pri_q, pri_i_ovr, pri_q_ovr}), 32'h0);
            chk("R7", "restart delayed", 32'({dly_i, dly_q, dly_i_ovr, dly_q_ovr}), 32'h0);
        end
        for (int t = 0; t < 2 * nsamp; t++) begin
            if (t % 2 == 0) drive_sample(t / 2, pat);
            @(posedge clk);
            @(negedge clk);
            check_tick(t, ddr, ed);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        run_seg(1'b0, 1'b1, 60, 0, 1'b1);  // single rate, rising launch
        run_seg(1'b0, 1'b0, 40, 2, 1'b0);  // single rate, falling launch
        run_seg(1'b1, 1'b0, 50, 2, 1'b0);  // double rate, no demux
        run_seg(1'b1, 1'b1, 60, 0, 1'b0);  // double rate, demux
        run_seg(1'b1, 1'b1, 40, 1, 1'b1);  // demux after reset, alternating extremes
        run_seg(1'b0, 1'b1, 30, 1, 1'b0);
        run_seg(1'b1, 1'b0, 10, 0, 1'b0);  // too short to refill: R7 zeros
        run_seg(1'b1, 1'b1, 45, 2, 1'b0);  // demux with ramp
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not end actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule